// File: doc/BRIEF.md
# Debug Module Register Interface

This block is the register file that an external debugger reaches over a simple request/response port. Each request carries a read/write flag, an address and a 32-bit write value. Exactly one cycle later the block answers with a response that carries an ok flag and, for reads, the 32-bit read value. The address space holds the following:

- a control register that selects a hart, requests a halt and resets the module;
- an abstract command status register with autoexec bits, a command error code, a busy flag and the number of data words;
- a read-only capability register that reports the program buffer depth;
- a write-only command register;
- two windows of general 32-bit words, one for data and one for the program buffer.

The block keeps one halt-request line for each hart and drives it directly. It does not execute commands itself. A write to the command register becomes a one-cycle pulse toward a command sequencer. The sequencer reports busy and error changes back through dedicated set inputs. Writing the control register with the active bit at zero returns the module to its reset state.

Top module: `dbg_regif`

## Requirements
- R1: Every request (`req_valid`) is answered on the next cycle with `resp_valid` high. `resp_ok` is 1 for a mapped address and 0 otherwise.
- R2: Addresses from `DATA_BASE` up to but not including `DATA_BASE+DATA_WORDS` hold readable and writable 32-bit data words. The first address past that range is unmapped.
- R3: Addresses from `PROG_BASE` up to but not including `PROG_BASE+PROG_WORDS` hold readable and writable program buffer words. The first address past that range is unmapped.
- R4: A control register read returns these fields:
  - bit 31: the halt request held for the selected hart;
  - bits 25:16: the hart selector;
  - bits 15:12: version, fixed at 1;
  - bit 5: authenticated, fixed at 1;
  - bits 3:2: hart status, where 00 is running, 01 is halted and 11 is no such hart (selector ≥ `NUM_HARTS`);
  - bit 1: the stored reset bit;
  - bit 0: the active bit.
- R5: A control write with bit 0 set does three things:
  - it stores bit 31, bit 1 and bits 25:16;
  - it drives bit 31 onto `hart_halt_req` of the newly selected hart, if that hart exists;
  - it leaves the halt requests of all other harts unchanged.
- R6: A control write with bit 0 clear has these effects:
  - all `hart_halt_req` bits clear;
  - the selector clears;
  - the halt, reset and active bits clear;
  - autoexec, busy and the error code clear.
- R7: An abstract status write stores autoexec from bits 31:24. It clears the error code (bits 10:8) only when the written bits 10:8 are zero. Any other written value leaves the error code unchanged.
- R8: A write to the command address gives `cmd_valid` high for exactly one cycle with `cmd_word` equal to the written value. A read of the command address returns 0 with ok.
- R9: The capability register reads as `PROG_WORDS` in bits 28:24 with all other bits 0. Bits 3:0 of the abstract status read as `DATA_WORDS`, and bit 12 reads as busy.
- R10: A request to an unmapped address returns ok=0 and read data 0, and it changes no state.
- R11: `seq_busy_wr` loads busy from `seq_busy`, and `seq_err_wr` loads the error code from `seq_err`. Either one takes priority over a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | 32 | Write value |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_ok | output | 1 | 1 = address mapped |
| resp_rdata | output | 32 | Read value, 0 on error and for writes |
| hart_halted | input | NUM_HARTS | Halted flag of each hart |
| hart_halt_req | output | NUM_HARTS | Halt request to each hart |
| cmd_valid | output | 1 | One-cycle pulse on a command write |
| cmd_word | output | 32 | Command value that goes with `cmd_valid` |
| seq_busy_wr | input | 1 | Sequencer busy update strobe |
| seq_busy | input | 1 | New busy value |
| seq_err_wr | input | 1 | Sequencer error update strobe |
| seq_err | input | 3 | New error code |

## Verification
The bench builds the block with three harts, two data words and four program buffer words. A selector value of 3 is then the first nonexistent hart, so the no-such-hart status can be reached. The first address past each window (0x06 and 0x24) then lies close to its mapped neighbours. With these small counts, every data and program word can be written and read back. The values read back also show the count fields in the status and capability registers as non-trivial numbers.

// File: rtl/dbg_regif.sv
module dbg_regif #(
  parameter int NUM_HARTS  = 4,
  parameter int DATA_WORDS = 4,
  parameter int PROG_WORDS = 8,
  parameter int ADDR_W     = 7,
  parameter int DATA_BASE  = 'h04,
  parameter int CTRL_ADDR  = 'h10,
  parameter int ASTAT_ADDR = 'h16,
  parameter int CAP_ADDR   = 'h17,
  parameter int CMD_ADDR   = 'h18,
  parameter int PROG_BASE  = 'h20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 resp_valid,
  output logic                 resp_ok,
  output logic [31:0]          resp_rdata,
  input  logic [NUM_HARTS-1:0] hart_halted,
  output logic [NUM_HARTS-1:0] hart_halt_req,
  output logic                 cmd_valid,
  output logic [31:0]          cmd_word,
  input  logic                 seq_busy_wr,
  input  logic                 seq_busy,
  input  logic                 seq_err_wr,
  input  logic [2:0]           seq_err
);
  localparam int SEL_W = 10;
  localparam int DI_W  = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
  localparam int PI_W  = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1;
  localparam int HI_W  = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  logic [31:0]      data_q [DATA_WORDS];
  logic [31:0]      prog_q [PROG_WORDS];
  logic [SEL_W-1:0] sel_q;
  logic             halt_q, reset_q, active_q, busy_q;
  logic [7:0]       autoexec_q;
  logic [2:0]       err_q;

  wire              wr = req_valid && req_write;
  wire              in_data = int'(req_addr) >= DATA_BASE && int'(req_addr) < DATA_BASE + DATA_WORDS;
  wire              in_prog = int'(req_addr) >= PROG_BASE && int'(req_addr) < PROG_BASE + PROG_WORDS;
  wire              at_ctrl = int'(req_addr) == CTRL_ADDR;
  wire              at_astat = int'(req_addr) == ASTAT_ADDR;
  wire              at_cap = int'(req_addr) == CAP_ADDR;
  wire              at_cmd = int'(req_addr) == CMD_ADDR;
  wire [ADDR_W-1:0] data_off = req_addr - ADDR_W'(DATA_BASE);
  wire [ADDR_W-1:0] prog_off = req_addr - ADDR_W'(PROG_BASE);
  wire [DI_W-1:0]   data_idx = data_off[DI_W-1:0];
  wire [PI_W-1:0]   prog_idx = prog_off[PI_W-1:0];
  wire              sel_ok = int'(sel_q) < NUM_HARTS;
  wire [HI_W-1:0]   sel_idx = sel_q[HI_W-1:0];
  wire [SEL_W-1:0]  new_sel = req_wdata[25:16];
  wire [HI_W-1:0]   new_idx = new_sel[HI_W-1:0];
  wire              new_ok = int'(new_sel) < NUM_HARTS;

  wire              halt_rep = sel_ok ? hart_halt_req[sel_idx] : halt_q;
  wire [1:0]        status = !sel_ok ? 2'b11 : (hart_halted[sel_idx] ? 2'b01 : 2'b00);
  wire [31:0]       ctrl_rd = {halt_rep, 5'b0, sel_q, 4'd1, 4'b0, 2'b0, 1'b1, 1'b0,
                               status, reset_q, active_q};
  wire [31:0]       astat_rd = {autoexec_q, 11'b0, busy_q, 1'b0, err_q, 4'b0, 4'(DATA_WORDS)};
  wire [31:0]       cap_rd = {3'b0, 5'(PROG_WORDS), 24'b0};

  logic        rd_ok;
  logic [31:0] rd_val;
  always_comb begin
    rd_ok  = 1'b1;
    rd_val = '0;
    if (in_data)       rd_val = data_q[data_idx];
    else if (in_prog)  rd_val = prog_q[prog_idx];
    else if (at_ctrl)  rd_val = ctrl_rd;
    else if (at_astat) rd_val = astat_rd;
    else if (at_cap)   rd_val = cap_rd;
    else if (at_cmd)   rd_val = '0;
    else               rd_ok  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_rdata <= '0;
      cmd_valid  <= 1'b0;
      cmd_word   <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_ok    <= req_valid && rd_ok;
      resp_rdata <= (req_valid && !req_write && rd_ok) ? rd_val : '0;
      cmd_valid  <= wr && at_cmd;
      if (wr && at_cmd) cmd_word <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DATA_WORDS; i++) data_q[i] <= '0;
      for (int i = 0; i < PROG_WORDS; i++) prog_q[i] <= '0;
    end else if (wr && in_data) begin
      data_q[data_idx] <= req_wdata;
    end else if (wr && in_prog) begin
      prog_q[prog_idx] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q         <= '0;
      halt_q        <= 1'b0;
      reset_q       <= 1'b0;
      active_q      <= 1'b0;
      hart_halt_req <= '0;
      autoexec_q    <= '0;
      busy_q        <= 1'b0;
      err_q         <= '0;
    end else begin
      if (wr && at_ctrl) begin
        if (req_wdata[0]) begin
          active_q <= 1'b1;
          halt_q   <= req_wdata[31];
          reset_q  <= req_wdata[1];
          sel_q    <= new_sel;
          if (new_ok) hart_halt_req[new_idx] <= req_wdata[31];
        end else begin
          active_q      <= 1'b0;
          halt_q        <= 1'b0;
          reset_q       <= 1'b0;
          sel_q         <= '0;
          hart_halt_req <= '0;
          autoexec_q    <= '0;
          busy_q        <= 1'b0;
          err_q         <= '0;
        end
      end
      if (wr && at_astat) begin
        autoexec_q <= req_wdata[31:24];
        if (req_wdata[10:8] == 3'd0) err_q <= '0;
      end
      if (seq_busy_wr) busy_q <= seq_busy;
      if (seq_err_wr)  err_q  <= seq_err;
    end
  end
endmodule

// File: rtl/dbg_regif_chk.sv
module dbg_regif_chk #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 7,
  parameter int CTRL_ADDR = 'h10,
  parameter int CMD_ADDR  = 'h18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 req_wdata0,
  input logic                 resp_valid,
  input logic                 resp_ok,
  input logic [31:0]          resp_rdata,
  input logic [NUM_HARTS-1:0] hart_halt_req,
  input logic                 cmd_valid
);
  wire ctrl_wr = req_valid && req_write && int'(req_addr) == CTRL_ADDR;

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R1
  resp_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R10
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ok) |-> resp_rdata == 32'd0);

  // R8
  cmd_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && int'(req_addr) == CMD_ADDR) |=> cmd_valid);

  // R8
  no_cmd_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && int'(req_addr) == CMD_ADDR) |=> !cmd_valid);

  // R6
  deactivate_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !req_wdata0) |=> hart_halt_req == '0);

  // R5
  halt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(hart_halt_req));
endmodule

bind dbg_regif dbg_regif_chk #(
  .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata0(req_wdata[0]), .resp_valid(resp_valid),
  .resp_ok(resp_ok), .resp_rdata(resp_rdata), .hart_halt_req(hart_halt_req),
  .cmd_valid(cmd_valid)
);

// File: tb/dbg_regif_bench.sv
module dbg_regif_bench;
  localparam int NH = 3;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          resp_valid, resp_ok;
  logic [31:0]   resp_rdata;
  logic [NH-1:0] hart_halted = '0;
  logic [NH-1:0] hart_halt_req;
  logic          cmd_valid;
  logic [31:0]   cmd_word;
  logic          seq_busy_wr = 1'b0, seq_busy = 1'b0, seq_err_wr = 1'b0;
  logic [2:0]    seq_err = '0;

  int vectors = 0;
  int fails = 0;
  logic        q_ok[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  dbg_regif #(.NUM_HARTS(NH), .DATA_WORDS(2), .PROG_WORDS(4), .ADDR_W(AW)) u_dbg_regif (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .resp_rdata(resp_rdata), .hart_halted(hart_halted),
    .hart_halt_req(hart_halt_req), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .seq_busy_wr(seq_busy_wr), .seq_busy(seq_busy), .seq_err_wr(seq_err_wr),
    .seq_err(seq_err));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q_ok.size() == 0) begin
        check("R1 unexpected response", 32'd1, 32'd0);
      end else begin
        logic        eok;
        logic [31:0] ed;
        string       t;
        eok = q_ok.pop_front();
        ed  = q_data.pop_front();
        t   = q_tag.pop_front();
        check({t, " ok"}, {31'd0, resp_ok}, {31'd0, eok});
        check({t, " data"}, resp_rdata, ed);
      end
    end
  end

  task automatic xfer(logic w, logic [AW-1:0] a, logic [31:0] d, logic eok,
                      logic [31:0] edata, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    q_ok.push_back(eok); q_data.push_back(edata); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset state
    xfer(0, 7'h10, 0, 1, 32'h0000_1020, "R4 reset ctrl");
    // R9 status and capability
    xfer(0, 7'h16, 0, 1, 32'h0000_0002, "R9 reset astat");
    xfer(0, 7'h17, 0, 1, 32'h0400_0000, "R9 capability");
    xfer(0, 7'h18, 0, 1, 32'h0, "R8 cmd reads zero");
    // R2 data window
    xfer(1, 7'h04, 32'hDEAD_BEEF, 1, 0, "R2 wr data0");
    xfer(1, 7'h05, 32'h0123_4567, 1, 0, "R2 wr data1");
    xfer(1, 7'h06, 32'hFFFF_FFFF, 0, 0, "R2 wr past data");
    xfer(0, 7'h04, 0, 1, 32'hDEAD_BEEF, "R2 rd data0");
    xfer(0, 7'h05, 0, 1, 32'h0123_4567, "R2 rd data1");
    xfer(0, 7'h06, 0, 0, 0, "R2 rd past data");
    // R3 program buffer
    for (int i = 0; i < 4; i++)
      xfer(1, AW'(32 + i), 32'hA000_0000 + i, 1, 0, "R3 wr prog");
    for (int i = 3; i >= 0; i--)
      xfer(0, AW'(32 + i), 0, 1, 32'hA000_0000 + i, "R3 rd prog");
    xfer(0, 7'h24, 0, 0, 0, "R3 rd past prog");
    // R5 select hart 1 with halt
    hart_halted = 3'b010;
    xfer(1, 7'h10, 32'h8001_0001, 1, 0, "R5 ctrl wr sel1");
    check("R5 halt lines", {29'd0, hart_halt_req}, 32'h2);
    xfer(0, 7'h10, 0, 1, 32'h8001_1025, "R4 ctrl halted hart");
    // R4 nonexistent hart
    xfer(1, 7'h10, 32'h0003_0003, 1, 0, "R5 ctrl wr sel3");
    check("R5 halt lines kept", {29'd0, hart_halt_req}, 32'h2);
    xfer(0, 7'h10, 0, 1, 32'h0003_102F, "R4 ctrl no hart");
    xfer(1, 7'h10, 32'h0002_0001, 1, 0, "R5 ctrl wr sel2");
    xfer(0, 7'h10, 0, 1, 32'h0002_1021, "R4 ctrl running");
    check("R5 other hart kept", {29'd0, hart_halt_req}, 32'h2);
    // R8 command pulse
    xfer(1, 7'h18, 32'h1234_5678, 1, 0, "R8 cmd wr");
    check("R8 cmd_valid high", {31'd0, cmd_valid}, 32'd1);
    check("R8 cmd_word", cmd_word, 32'h1234_5678);
    @(negedge clk);
    check("R8 cmd_valid one cycle", {31'd0, cmd_valid}, 32'd0);
    // R11 sequencer updates
    @(negedge clk);
    seq_busy_wr = 1; seq_busy = 1; seq_err_wr = 1; seq_err = 3'd3;
    @(negedge clk);
    seq_busy_wr = 0; seq_err_wr = 0;
    xfer(0, 7'h16, 0, 1, 32'h0000_1302, "R11 busy err set");
    // R7 error clear rule
    xfer(1, 7'h16, 32'hA500_0100, 1, 0, "R7 astat wr err1");
    xfer(0, 7'h16, 0, 1, 32'hA500_1302, "R7 err kept");
    xfer(1, 7'h16, 32'h5A00_0000, 1, 0, "R7 astat wr err0");
    xfer(0, 7'h16, 0, 1, 32'h5A00_1002, "R7 err cleared");
    // R11 priority over bus clear
    seq_err_wr = 1; seq_err = 3'd5;
    xfer(1, 7'h16, 32'h5A00_0000, 1, 0, "R11 same cycle wr");
    seq_err_wr = 0;
    xfer(0, 7'h16, 0, 1, 32'h5A00_1502, "R11 sequencer wins");
    // R10 unmapped address
    xfer(1, 7'h30, 32'h0000_0000, 0, 0, "R10 wr unmapped");
    xfer(0, 7'h30, 0, 0, 0, "R10 rd unmapped");
    xfer(0, 7'h10, 0, 1, 32'h0002_1021, "R10 ctrl untouched");
    check("R10 halt lines untouched", {29'd0, hart_halt_req}, 32'h2);
    // R6 deactivate
    hart_halted = 3'b000;
    xfer(1, 7'h10, 32'h8001_0000, 1, 0, "R6 ctrl deactivate");
    check("R6 halt lines cleared", {29'd0, hart_halt_req}, 32'h0);
    xfer(0, 7'h10, 0, 1, 32'h0000_1020, "R6 ctrl after reset");
    xfer(0, 7'h16, 0, 1, 32'h0000_0002, "R6 astat after reset");
    repeat (3) @(negedge clk);
    check("R1 pending responses", q_ok.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule